// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block turns a fast reference clock into the serial clock and the four chip-select lines of a SPI flash master. A configuration word sets the enable, the clock polarity and phase, a 4-bit clock divisor, a chip-select field and a decode-mode bit. A delay word holds four 8-bit counts, in reference clocks, that set the setup time, the hold time, the pause inside a transfer and the minimum deselect time.

A sequencer drives the block with three single-cycle pulses. A start pulse opens a transfer. A byte-done pulse asks for a pause between two words. An end pulse closes the transfer. The block answers with serial clock edges and with registered sample and launch strobes that line up with those edges. It reports idle once every timing phase has run out. Data shifting is done outside this block.

Top module: `spi_sclk_cs_gen`

## Requirements
- R1: After reset, cs_n is 4'b1111, sclk is low, sample_stb and launch_stb are 0 and idle is 1.
- R2: While clocking, sclk changes level every div+1 reference clocks. div is the 4-bit field at cfg_word[22:19], so the serial clock runs at the reference clock divided by 2*(div+1). div=15 is the slowest setting.
- R3: The configuration fields are enable at cfg_word[0], CPOL at [1], CPHA at [2], decode select at [9], chip select at [13:10] and div at [22:19]. CPOL, CPHA, decode select, chip select and div are captured only on cycles where enable is 0 and the block is idle. Changing them while enable is 1 has no effect.
- R4: sclk rests at the CPOL level whenever chip select is inactive, and also between bits while the clock is paused.
- R5: With CPHA=0, sample_stb pulses on the edge that moves sclk away from its rest level and launch_stb pulses on the edge that returns it. With CPHA=1 the two are swapped. Each strobe is high only in the cycle in which sclk shows its new level.
- R6: With decode select 0, an active transfer drives cs_n active-low one-hot: select 0 gives 4'b1110, 1 gives 4'b1101, 2 gives 4'b1011 and 3 gives 4'b0111. Select values 4 to 15 leave cs_n at 4'b1111.
- R7: With decode select 1, an active transfer drives the 4-bit select field onto cs_n unchanged.
- R8: cs_n goes active one cycle after a start pulse is accepted. The first sclk edge follows S+div+2 reference clocks later, where S is dly_word[7:0].
- R9: From the last sclk edge to cs_n returning to 4'b1111 takes H+2*(div+1)+3 reference clocks, where H is dly_word[15:8].
- R10: A byte_done pulse during a transfer lengthens the next rest interval of sclk by G+div+1 reference clocks, where G is dly_word[23:16]. G=0 gives no pause. Chip select stays active during the pause.
- R11: After cs_n goes inactive, idle rises D+2*div+2 cycles later, where D is dly_word[31:24]. The cs_n inactive time before another transfer can begin is therefore at least D+2*(div+1)+1 reference clocks.
- R12: idle is 1 only when no transfer or timing phase is active. A start pulse is ignored while enable is 0. byte_done and xfer_end are ignored while idle.
- R13: An end request is held until the next point where a rising edge away from rest would occur, and that edge is suppressed. An end given before the first edge gives a transfer with no clock edges. An end request takes priority over a pending pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word (enable, mode, select, divisor) |
| dly_word | input | 32 | Four 8-bit delay counts: setup [7:0], hold [15:8], pause [23:16], deselect [31:24] |
| xfer_start | input | 1 | Pulse that opens a transfer |
| xfer_end | input | 1 | Pulse that asks the transfer to close |
| byte_done | input | 1 | Pulse that asks for a pause before the next bit |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Chip-select lines, one-hot active-low or raw code |
| sample_stb | output | 1 | Pulse on the edge where the slave's data is to be sampled |
| launch_stb | output | 1 | Pulse on the edge where new data is to be driven |
| idle | output | 1 | High when no transfer or timing phase is active |

## Verification
The embedded assertions check these properties on every cycle:
- sclk sits at the CPOL level whenever chip select is inactive.
- cs_n has at most one active line in one-hot mode, and is fully inactive while idle.
- The two strobes never pulse together.
- The half-period counter stays within the divisor.
- The captured configuration holds steady while enabled.
- A disabled block stays idle.

The exact cycle positions of each timing phase can only be shown by the bench scenarios. Its scoreboard predicts every chip-select and clock transition from the delay counts and the divisor, and compares the cycle and the value of each one. That covers the setup, hold, pause and deselect times, the strobe polarity in all four modes, the end-before-first-edge case and the slowest divisor.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

    localparam int CS_W     = 4;
    localparam int DIV_W    = 4;
    localparam int DLY_W    = 8;
    localparam int CNT_W    = DLY_W + 2;
    localparam int WORD_W   = 32;

    localparam int EN_BIT   = 0;
    localparam int CPOL_BIT = 1;
    localparam int CPHA_BIT = 2;
    localparam int DEC_BIT  = 9;
    localparam int SEL_LSB  = 10;
    localparam int DIV_LSB  = 19;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_RUN   = 3'd2,
        ST_GAP   = 3'd3,
        ST_HOLD  = 3'd4,
        ST_DESEL = 3'd5
    } tg_state_e;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic             dec;
        logic [CS_W-1:0]  sel;
        logic [DIV_W-1:0] div;
    } tg_cfg_t;

    typedef struct packed {
        logic [DLY_W-1:0] desel;
        logic [DLY_W-1:0] gap;
        logic [DLY_W-1:0] hold;
        logic [DLY_W-1:0] setup;
    } tg_dly_t;

    function automatic tg_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        tg_cfg_t c;
        c.cpol = w[CPOL_BIT];
        c.cpha = w[CPHA_BIT];
        c.dec  = w[DEC_BIT];
        c.sel  = w[SEL_LSB +: CS_W];
        c.div  = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    // Hold phase length: the state already spends div+1 cycles before entry
    function automatic logic [CNT_W-1:0] hold_load(input logic [DLY_W-1:0] h,
                                                   input logic [DIV_W-1:0] d);
        return CNT_W'(h) + CNT_W'(d) + CNT_W'(3);
    endfunction

    // Deselect phase length before the block reports idle
    function automatic logic [CNT_W-1:0] desel_load(input logic [DLY_W-1:0] ds,
                                                    input logic [DIV_W-1:0] d);
        return CNT_W'(ds) + (CNT_W'(d) << 1) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/spi_tg_cfg_latch.sv
module spi_tg_cfg_latch
    import spi_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              blk_idle,
    output logic              enable,
    output tg_cfg_t           cfg_q
);

    assign enable = cfg_word[EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!enable && blk_idle) begin
            cfg_q <= unpack_cfg(cfg_word);
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        enable |=> $stable(cfg_q)) else $error("cfg changed while enabled"); // R3

endmodule

// File: rtl/spi_tg_clkgen.sv
module spi_tg_clkgen
    import spi_tg_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          stop,
    input  logic          cpha,
    input  logic [DW-1:0] div,
    output logic          ph,
    output logic          lead_tick,
    output logic          samp_q,
    output logic          launch_q
);

    logic [DW-1:0] hcnt;
    logic          tick;
    logic          edge_go;
    logic          leading;

    assign tick      = run && (hcnt == div);
    assign lead_tick = tick && !ph;
    assign leading   = !ph;
    assign edge_go   = tick && !(stop && leading);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt     <= '0;
            ph       <= 1'b0;
            samp_q   <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            samp_q   <= edge_go && (leading ^ cpha);
            launch_q <= edge_go && !(leading ^ cpha);
            if (!run) begin
                hcnt <= '0;
                ph   <= 1'b0;
            end else if (tick) begin
                hcnt <= '0;
                if (edge_go) ph <= ~ph;
            end else begin
                hcnt <= hcnt + DW'(1);
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(samp_q && launch_q)) else $error("both strobes"); // R5

    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (rst)
        hcnt <= div) else $error("half-period counter overrun"); // R2

    AST_PARK_NORUN: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!run -> !ph)) else $error("clock left rest level while stopped"); // R4

endmodule

// File: rtl/spi_tg_seq.sv
module spi_tg_seq
    import spi_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             start,
    input  logic             endreq,
    input  logic             byte_done,
    input  tg_dly_t          dly,
    input  logic [DIV_W-1:0] div,
    input  logic             lead_tick,
    output tg_state_e        state,
    output logic             run,
    output logic             stop,
    output logic             cs_active,
    output logic             idle
);

    logic [CNT_W-1:0] cnt;
    logic             end_pend;
    logic             gap_pend;
    logic             live;

    assign run       = (state == ST_RUN);
    assign idle      = (state == ST_IDLE);
    assign live      = (state == ST_SETUP) || (state == ST_RUN) || (state == ST_GAP);
    assign cs_active = live || (state == ST_HOLD);
    assign stop      = end_pend || (gap_pend && (dly.gap != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            end_pend <= 1'b0;
            gap_pend <= 1'b0;
        end else begin
            if (live && endreq)    end_pend <= 1'b1;
            if (live && byte_done) gap_pend <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    end_pend <= 1'b0;
                    gap_pend <= 1'b0;
                    if (enable && start) begin
                        state <= ST_SETUP;
                        cnt   <= CNT_W'(dly.setup);
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) state <= ST_RUN;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                ST_RUN: begin
                    if (lead_tick && end_pend) begin
                        state    <= ST_HOLD;
                        cnt      <= hold_load(dly.hold, div);
                        end_pend <= 1'b0;
                        gap_pend <= 1'b0;
                    end else if (lead_tick && gap_pend) begin
                        gap_pend <= 1'b0;
                        if (dly.gap != '0) begin
                            state <= ST_GAP;
                            cnt   <= CNT_W'(dly.gap) - CNT_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) state <= ST_RUN;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        state <= ST_DESEL;
                        cnt   <= desel_load(dly.desel, div);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_DESEL: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DISABLED_STAYS: assert property (@(posedge clk) disable iff (rst)
        (idle && !enable) |=> idle) else $error("left idle while disabled"); // R12

    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (run && lead_tick && end_pend) |=> (state == ST_HOLD)) else $error("end not honoured"); // R13

endmodule

// File: rtl/spi_tg_csenc.sv
module spi_tg_csenc
    import spi_tg_pkg::*;
#(
    parameter int NCS = CS_W
) (
    input  logic           active,
    input  logic           dec,
    input  logic [NCS-1:0] sel,
    output logic [NCS-1:0] cs_n
);

    logic [NCS-1:0] onehot_n;

    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign onehot_n[i] = !(active && (sel == NCS'(i)));
    end

    always_comb begin
        if (!active)  cs_n = '1;
        else if (dec) cs_n = sel;
        else          cs_n = onehot_n;
    end

endmodule

// File: rtl/spi_sclk_cs_gen.sv
module spi_sclk_cs_gen
    import spi_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [WORD_W-1:0] dly_word,
    input  logic              xfer_start,
    input  logic              xfer_end,
    input  logic              byte_done,
    output logic              sclk,
    output logic [CS_W-1:0]   cs_n,
    output logic              sample_stb,
    output logic              launch_stb,
    output logic              idle
);

    tg_cfg_t   cfg_q;
    tg_dly_t   dly;
    tg_state_e state;
    logic      enable;
    logic      run;
    logic      stop;
    logic      cs_active;
    logic      ph;
    logic      lead_tick;

    assign dly = tg_dly_t'(dly_word);

    spi_tg_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .blk_idle (idle),
        .enable   (enable),
        .cfg_q    (cfg_q)
    );

    spi_tg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .start     (xfer_start),
        .endreq    (xfer_end),
        .byte_done (byte_done),
        .dly       (dly),
        .div       (cfg_q.div),
        .lead_tick (lead_tick),
        .state     (state),
        .run       (run),
        .stop      (stop),
        .cs_active (cs_active),
        .idle      (idle)
    );

    spi_tg_clkgen #(.DW(DIV_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .stop      (stop),
        .cpha      (cfg_q.cpha),
        .div       (cfg_q.div),
        .ph        (ph),
        .lead_tick (lead_tick),
        .samp_q    (sample_stb),
        .launch_q  (launch_stb)
    );

    spi_tg_csenc #(.NCS(CS_W)) u_cs (
        .active (cs_active),
        .dec    (cfg_q.dec),
        .sel    (cfg_q.sel),
        .cs_n   (cs_n)
    );

    assign sclk = ph ^ cfg_q.cpol;

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        !cs_active |-> (sclk == cfg_q.cpol)) else $error("sclk off rest level"); // R4

    AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (rst)
        idle |-> (cs_n == '1)) else $error("select active while idle"); // R12

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.dec |-> ($countones(~cs_n) <= 1)) else $error("multiple selects"); // R6

endmodule

// File: tb/spi_sclk_cs_gen_tb.sv
module spi_sclk_cs_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic [31:0] dly_word = '0;
    logic        xfer_start = 1'b0;
    logic        xfer_end = 1'b0;
    logic        byte_done = 1'b0;
    logic        sclk;
    logic [3:0]  cs_n;
    logic        sample_stb;
    logic        launch_stb;
    logic        idle;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    logic cur_cpol = 1'b0;
    logic cur_cpha = 1'b0;
    logic prev_sclk;
    logic [3:0] prev_cs;

    // scoreboard: kind 0 = chip-select change, 1 = sclk change
    int    q_kind[$];
    int    q_cyc[$];
    int    q_val[$];
    string q_req[$];

    always #2.5 clk = ~clk;   // 200 MHz

    spi_sclk_cs_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_word   (cfg_word),
        .dly_word   (dly_word),
        .xfer_start (xfer_start),
        .xfer_end   (xfer_end),
        .byte_done  (byte_done),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .sample_stb (sample_stb),
        .launch_stb (launch_stb),
        .idle       (idle)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int c, input int v, input string req);
        q_kind.push_back(kind);
        q_cyc.push_back(c);
        q_val.push_back(v);
        q_req.push_back(req);
    endtask

    // monitor: pops the scoreboard on each observed transition
    always @(negedge clk) begin
        if (!rst && mon_on) begin
            if (sclk !== prev_sclk) begin
                if (q_kind.size() == 0) begin
                    chk(0, "R2", "unexpected sclk edge", int'(sclk), int'(prev_sclk));
                end else begin
                    int k; int c; int v; string r;
                    k = q_kind.pop_front(); c = q_cyc.pop_front();
                    v = q_val.pop_front();  r = q_req.pop_front();
                    chk(k == 1, r, "event kind (sclk)", 1, k);
                    chk(c == cyc, r, "sclk edge cycle", cyc, c);
                    chk(v == int'(sclk), "R4", "sclk level", int'(sclk), v);
                    begin
                        logic lead; logic es;
                        lead = (sclk != cur_cpol);
                        es = lead ^ cur_cpha;
                        chk(sample_stb == es, "R5", "sample_stb on edge", int'(sample_stb), int'(es));
                        chk(launch_stb == !es, "R5", "launch_stb on edge", int'(launch_stb), int'(!es));
                    end
                end
            end else if (sample_stb || launch_stb) begin
                chk(0, "R5", "strobe without edge", int'({sample_stb, launch_stb}), 0);
            end
            if (cs_n !== prev_cs) begin
                if (q_kind.size() == 0) begin
                    chk(0, "R12", "unexpected cs_n change", int'(cs_n), int'(prev_cs));
                end else begin
                    int k; int c; int v; string r;
                    k = q_kind.pop_front(); c = q_cyc.pop_front();
                    v = q_val.pop_front();  r = q_req.pop_front();
                    chk(k == 0, r, "event kind (cs)", 0, k);
                    chk(c == cyc, r, "cs_n change cycle", cyc, c);
                    chk(v == int'(cs_n), r, "cs_n value", int'(cs_n), v);
                end
            end
        end
        prev_sclk <= sclk;
        prev_cs   <= cs_n;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] mk_cfg(input logic en, input logic cpol, input logic cpha,
                                           input logic dec, input logic [3:0] sel,
                                           input logic [3:0] dv);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[1] = cpol; w[2] = cpha; w[9] = dec;
        w[13:10] = sel; w[22:19] = dv;
        return w;
    endfunction

    function automatic logic [3:0] exp_cs(input logic [3:0] sel, input logic dec);
        if (dec) return sel;
        case (sel)
            4'd0: return 4'b1110;
            4'd1: return 4'b1101;
            4'd2: return 4'b1011;
            4'd3: return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic set_cfg(input logic cpol, input logic cpha, input logic dec,
                           input logic [3:0] sel, input logic [3:0] dv);
        mon_on = 1'b0;
        @(negedge clk);
        cfg_word = mk_cfg(1'b0, cpol, cpha, dec, sel, dv);
        @(negedge clk);
        @(negedge clk);
        cfg_word[0] = 1'b1;
        cur_cpol = cpol;
        cur_cpha = cpha;
        @(negedge clk);
        chk(sclk == cpol, "R4", "sclk rest level after config", int'(sclk), int'(cpol));
        mon_on = 1'b1;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // driver: computes the expected timeline, then drives the handshakes
    task automatic run_xfer(input int s, input int h, input int g, input int d,
                            input int nbits, input int gapbit, input logic [3:0] cs_exp,
                            input int dv, input string req);
        int k0; int hp; int lead; int trail; int tgap; int tend; int ln; int csr; int idl;
        @(negedge clk);
        dly_word = {d[7:0], g[7:0], h[7:0], s[7:0]};
        @(negedge clk);
        k0 = cyc + 1;
        hp = dv + 1;
        tgap = -1;
        tend = k0 + 1;
        if (cs_exp != 4'hF) push(0, k0, int'(cs_exp), "R8");
        lead = k0 + s + dv + 2;
        ln = lead;
        for (int i = 0; i < nbits; i++) begin
            push(1, lead, int'(!cur_cpol), (i == 0) ? "R8" : req);
            trail = lead + hp;
            push(1, trail, int'(cur_cpol), "R2");
            if (i == nbits - 1) begin
                tend = trail;
                ln = trail + hp;
            end else if (i == gapbit) begin
                tgap = trail;
                lead = trail + hp + ((g != 0) ? (g + hp) : 0);
            end else begin
                lead = trail + hp;
            end
        end
        csr = ln + h + dv + 4;
        if (cs_exp != 4'hF) push(0, csr, 15, "R9");
        idl = csr + d + 2 * dv + 2;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(idle == 1'b0, "R12", "idle low during transfer", int'(idle), 0);
        if (tgap >= 0) begin
            wait_to(tgap - 1);
            byte_done = 1'b1;
            @(negedge clk);
            byte_done = 1'b0;
        end
        wait_to(tend - 1);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
        wait_to(idl - 1);
        chk(idle == 1'b0, "R11", "idle still low before deselect ends", int'(idle), 0);
        @(negedge clk);
        chk(idle == 1'b1, "R11", "idle after deselect time", int'(idle), 1);
        chk(q_kind.size() == 0, req, "all scheduled transitions seen", q_kind.size(), 0);
        q_kind.delete(); q_cyc.delete(); q_val.delete(); q_req.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 4'hF, "R1", "cs_n after reset", int'(cs_n), 15);
        chk(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);
        chk(idle == 1'b1, "R1", "idle after reset", int'(idle), 1);
        chk(!sample_stb && !launch_stb, "R1", "strobes after reset",
            int'({sample_stb, launch_stb}), 0);
        mon_on = 1'b1;

        // start while disabled, end/byte_done while idle: all ignored (R12)
        @(negedge clk);
        xfer_start = 1'b1; xfer_end = 1'b1; byte_done = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0; xfer_end = 1'b0; byte_done = 1'b0;
        repeat (8) @(negedge clk);
        chk(cs_n == 4'hF, "R12", "start ignored while disabled", int'(cs_n), 15);
        chk(idle == 1'b1, "R12", "still idle while disabled", int'(idle), 1);

        // mode 0, fastest clock, select 0
        set_cfg(1'b0, 1'b0, 1'b0, 4'd0, 4'd0);
        run_xfer(1, 2, 0, 3, 3, -1, exp_cs(4'd0, 1'b0), 0, "R2");

        // mode 3, div 2, select 2, pause after bit 0
        set_cfg(1'b1, 1'b1, 1'b0, 4'd2, 4'd2);
        run_xfer(2, 1, 4, 2, 3, 0, exp_cs(4'd2, 1'b0), 2, "R10");

        // byte_done with zero pause count gives no stretch
        run_xfer(0, 0, 0, 0, 3, 1, exp_cs(4'd2, 1'b0), 2, "R10");

        // mode 1, slowest divisor, raw decode code
        set_cfg(1'b0, 1'b1, 1'b1, 4'd9, 4'd15);
        run_xfer(0, 0, 0, 0, 2, -1, exp_cs(4'd9, 1'b1), 15, "R7");

        // mode 2, select 3
        set_cfg(1'b1, 1'b0, 1'b0, 4'd3, 4'd1);
        run_xfer(3, 5, 0, 4, 2, -1, exp_cs(4'd3, 1'b0), 1, "R6");

        // one-hot select out of range keeps all lines high
        set_cfg(1'b0, 1'b0, 1'b0, 4'd5, 4'd0);
        run_xfer(0, 1, 0, 1, 1, -1, 4'hF, 0, "R6");

        // end before first edge: no clock edges at all
        set_cfg(1'b0, 1'b0, 1'b0, 4'd1, 4'd3);
        run_xfer(2, 2, 0, 2, 0, -1, exp_cs(4'd1, 1'b0), 3, "R13");

        // changes while enabled have no effect
        @(negedge clk);
        mon_on = 1'b0;
        cfg_word = mk_cfg(1'b1, 1'b1, 1'b1, 1'b1, 4'd2, 4'd5);
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R3", "CPOL change while enabled ignored", int'(sclk), 0);
        mon_on = 1'b1;
        run_xfer(1, 1, 0, 1, 2, -1, exp_cs(4'd1, 1'b0), 3, "R3");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule